// File: doc/BRIEF.md
# DMA Transfer Counter with Reload

This unit tracks the remaining transfer units of one DMA channel. It keeps two 24-bit values. The first is the live count, which drops by one on every transfer-unit strobe. The second is a shadow reload value. Software can rewrite the shadow at any time, and the live count is not affected when it does. A programmed count of zero stands for the largest block, 2^24 units. For 16-byte transfers, one strobe marks one complete 128-bit unit.

When a strobe arrives while the live count holds 1, the block ends. A one-cycle done pulse follows on the next cycle. In that same edge the live count takes a new value. With reload enabled it takes the shadow value, so the next block can start on the very next strobe. With reload disabled it becomes zero.

Both values are read and written through a 32-bit register port with two decoded word addresses and combinational read data. There are two resets. The asynchronous power-on reset clears everything. The synchronous manual reset clears the live count and the done pulse but keeps the shadow value.

Top module: `dma_xfer_counter`

## Requirements
- R1: After power-on reset, both registers read 0 and `xfer_done` is low.
- R2: Only bits 23:0 of each register are stored. Bits 31:24 always read 0, and written values in bits 31:24 are dropped.
- R3: Each `unit_strobe` decrements the live count by one when the count is not 1 and the same cycle has no software write to the count register.
- R4: A strobe that finds the count at 1 ends the block. `xfer_done` is high for exactly the next cycle. Without such a strobe, `xfer_done` stays low.
- R5: A live count of 0 means 2^24 units. A strobe at 0 gives 0xFFFFFF and does not end the block.
- R6: With `reload_en` high at the final strobe, the live count takes the shadow value in the same edge that raises done.
- R7: With `reload_en` low at the final strobe, the live count becomes 0, and the shadow value has no effect.
- R8: Writing the shadow register leaves the live count unchanged.
- R9: A software write to the count register in the same cycle as a strobe takes priority. The strobe is lost, and no done pulse is produced.
- R10: Manual reset (`man_rst_n` low at a clock edge) clears the live count and `xfer_done` and keeps the shadow value.
- R11: The live count is at byte address 0x00 and the shadow at 0x04. Other addresses read 0 and ignore writes.
- R12: If the shadow is written in the cycle of a final strobe with reload enabled, the live count takes the old shadow value, and the new value is stored for the following block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Asynchronous power-on reset, active low |
| man_rst_n | input | 1 | Synchronous manual reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| unit_strobe | input | 1 | One completed transfer unit |
| reload_en | input | 1 | Copy shadow into live count at block end |
| xfer_done | output | 1 | One-cycle pulse after the final unit |

## Verification
A wrong live count shows up in the read data at address 0x00 in the cycle right after the edge that corrupted it. Even if nobody reads the count, the error still appears: the done pulse comes at the wrong strobe, at the latest at the end of that block. A wrong shadow value stays hidden until the next reload, unless address 0x04 is read. For that reason the random stimulus reads both addresses often and ends blocks often by keeping counts small. A lost or extra done pulse is seen one cycle after the strobe that should or should not have ended the block.

// File: rtl/dmactr_pkg.sv
package dmactr_pkg;
  parameter int unsigned CTR_W = 24;
  typedef logic [CTR_W-1:0] ctr_t;

  function automatic ctr_t ctr_dec(input ctr_t c);
    return c - ctr_t'(1);
  endfunction

  function automatic logic ctr_is_last(input ctr_t c);
    return c == ctr_t'(1);
  endfunction

  function automatic ctr_t ctr_after_last(input logic rel, input ctr_t shadow);
    return rel ? shadow : '0;
  endfunction
endpackage

// File: rtl/dmactr_regport.sv
module dmactr_regport
  import dmactr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] RLD_ADDR = 8'h04
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  ctr_t              cnt_q,
  input  ctr_t              rld_q,
  output logic              cnt_wr,
  output logic              rld_wr,
  output ctr_t              wval,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - CTR_W;

  logic hit_cnt, hit_rld;
  assign hit_cnt = (addr == CNT_ADDR);
  assign hit_rld = (addr == RLD_ADDR);
  assign cnt_wr  = we && hit_cnt;
  assign rld_wr  = we && hit_rld;
  assign wval    = wdata[CTR_W-1:0];

  always_comb begin
    rdata = '0;
    if (hit_cnt)      rdata = {{PAD_W{1'b0}}, cnt_q};
    else if (hit_rld) rdata = {{PAD_W{1'b0}}, rld_q};
  end
endmodule

// File: rtl/dmactr_shadow.sv
module dmactr_shadow
  import dmactr_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic wr,
  input  ctr_t wval,
  output ctr_t rld_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)  rld_q <= '0;
    else if (wr) rld_q <= wval;
  end
endmodule

// File: rtl/dmactr_live.sv
module dmactr_live
  import dmactr_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic man_n,
  input  logic cnt_wr,
  input  ctr_t wval,
  input  logic strobe,
  input  logic reload_en,
  input  ctr_t rld_q,
  output ctr_t cnt_q,
  output logic done_q,
  output logic final_evt
);
  assign final_evt = strobe && !cnt_wr && ctr_is_last(cnt_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!man_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= final_evt;
      if (cnt_wr)         cnt_q <= wval;
      else if (final_evt) cnt_q <= ctr_after_last(reload_en, rld_q);
      else if (strobe)    cnt_q <= ctr_dec(cnt_q);
    end
  end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
  import dmactr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              man_rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              unit_strobe,
  input  logic              reload_en,
  output logic              xfer_done
);
  ctr_t cnt_q, rld_q, wval;
  logic cnt_wr, rld_wr, final_evt, done_q;

  dmactr_regport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cnt_q(cnt_q), .rld_q(rld_q),
    .cnt_wr(cnt_wr), .rld_wr(rld_wr), .wval(wval), .rdata(reg_rdata)
  );

  dmactr_shadow u_shadow (
    .clk(clk), .por_n(por_rst_n), .wr(rld_wr), .wval(wval), .rld_q(rld_q)
  );

  dmactr_live u_live (
    .clk(clk), .por_n(por_rst_n), .man_n(man_rst_n),
    .cnt_wr(cnt_wr), .wval(wval), .strobe(unit_strobe),
    .reload_en(reload_en), .rld_q(rld_q),
    .cnt_q(cnt_q), .done_q(done_q), .final_evt(final_evt)
  );

  assign xfer_done = done_q;
endmodule

// File: rtl/dmactr_chk.sv
module dmactr_chk
  import dmactr_pkg::*;
(
  input logic        clk,
  input logic        por_n,
  input logic        man_n,
  input logic        strobe,
  input logic        reload_en,
  input logic        cnt_wr,
  input logic        rld_wr,
  input ctr_t        wval,
  input ctr_t        cnt_q,
  input ctr_t        rld_q,
  input logic        done_q,
  input logic        final_evt,
  input logic [31:0] rdata
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    rdata[31:24] == 8'h00);

  // R3
  dec_chk: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    (strobe && !cnt_wr && !final_evt) |=> cnt_q == ctr_t'($past(cnt_q) - 1'b1));

  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    final_evt |=> done_q);

  // R4
  no_stray_done_chk: assert property (@(posedge clk) disable iff (!por_n)
    !final_evt |=> !done_q);

  // R5
  zero_is_max_chk: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    (strobe && !cnt_wr && cnt_q == '0) |=> (cnt_q == '1 && !done_q));

  // R6 R12
  reload_copy_chk: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    (final_evt && reload_en) |=> cnt_q == $past(rld_q));

  // R7
  no_reload_chk: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    (final_evt && !reload_en) |=> cnt_q == '0);

  // R8
  shadow_quiet_chk: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    (rld_wr && !cnt_wr && !strobe) |=> $stable(cnt_q));

  // R9
  sw_wins_chk: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    cnt_wr |=> (cnt_q == $past(wval) && !done_q));

  // R10
  man_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!man_n && !rld_wr) |=> (cnt_q == '0 && !done_q && rld_q == $past(rld_q)));
endmodule

bind dma_xfer_counter dmactr_chk u_chk (
  .clk(clk), .por_n(por_rst_n), .man_n(man_rst_n),
  .strobe(unit_strobe), .reload_en(reload_en),
  .cnt_wr(cnt_wr), .rld_wr(rld_wr), .wval(wval),
  .cnt_q(cnt_q), .rld_q(rld_q), .done_q(done_q),
  .final_evt(final_evt), .rdata(reg_rdata)
);

// File: tb/tb_dma_xfer_counter.sv
module tb_dma_xfer_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        por_rst_n, man_rst_n, reg_we, unit_strobe, reload_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        xfer_done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [23:0] m_cnt, m_rld;
  logic        m_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_counter dut (
    .clk(clk), .por_rst_n(por_rst_n), .man_rst_n(man_rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .unit_strobe(unit_strobe),
    .reload_en(reload_en), .xfer_done(xfer_done)
  );

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return {8'h00, m_cnt};
    if (a == 8'h04) return {8'h00, m_rld};
    return 32'h0;
  endfunction

  function automatic logic [23:0] m_next(input logic wr_c, input logic [23:0] wv,
                                         input logic stb, input logic ren,
                                         input logic [23:0] c, input logic [23:0] r);
    if (wr_c) return wv;
    if (stb && c == 24'd1) return ren ? r : 24'd0;
    if (stb) return c + 24'hFFFFFF;
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [7:0] a,
                      input logic [31:0] wd, input logic stb, input logic ren,
                      input logic mrst_n);
    logic wr_c, wr_r;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    unit_strobe = stb; reload_en = ren; man_rst_n = mrst_n;
    wr_c = we && a == 8'h00;
    wr_r = we && a == 8'h04;
    @(posedge clk);
    if (!mrst_n) begin
      m_cnt = 24'd0; m_done = 1'b0;
    end else begin
      m_done = stb && !wr_c && m_cnt == 24'd1;
      m_cnt = m_next(wr_c, wd[23:0], stb, ren, m_cnt, m_rld);
    end
    if (wr_r) m_rld = wd[23:0];
    #1;
    chk({tag, " rdata"}, reg_rdata, m_read(a));
    chk({tag, " done"}, {31'b0, xfer_done}, {31'b0, m_done});
  endtask

  task automatic idle_read(input string tag, input logic [7:0] a);
    step(tag, 1'b0, a, 32'h0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    por_rst_n = 1'b0; man_rst_n = 1'b1; reg_we = 1'b0; reg_addr = 8'h00;
    reg_wdata = 32'h0; unit_strobe = 1'b0; reload_en = 1'b0;
    m_cnt = 24'd0; m_rld = 24'd0; m_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) por_rst_n = 1'b1;

    // R1 reset state
    idle_read("R1 count", 8'h00);
    chk("R1 count zero", reg_rdata, 32'h0);
    idle_read("R1 shadow", 8'h04);
    chk("R1 shadow zero", reg_rdata, 32'h0);
    chk("R1 done low", {31'b0, xfer_done}, 32'h0);

    // R2 upper bits dropped
    step("R2 write", 1'b1, 8'h00, 32'hAB000005, 1'b0, 1'b0, 1'b1);
    chk("R2 upper bits", reg_rdata, 32'h00000005);

    // R11 unmapped address
    step("R11 write", 1'b1, 8'h0C, 32'h00000077, 1'b0, 1'b0, 1'b1);
    chk("R11 unmapped reads 0", reg_rdata, 32'h0);
    idle_read("R11 count kept", 8'h00);
    chk("R11 count unchanged", reg_rdata, 32'h5);

    // R3 decrement
    step("R3 strobe", 1'b0, 8'h00, 32'h0, 1'b1, 1'b1, 1'b1);
    chk("R3 count minus one", reg_rdata, 32'h4);

    // R8 shadow write mid-block
    step("R8 shadow write", 1'b1, 8'h04, 32'h00000007, 1'b0, 1'b1, 1'b1);
    idle_read("R8 count", 8'h00);
    chk("R8 count undisturbed", reg_rdata, 32'h4);

    // R4 R6 end of block with reload
    for (int i = 0; i < 3; i++) step("R3 run", 1'b0, 8'h00, 32'h0, 1'b1, 1'b1, 1'b1);
    step("R6 final", 1'b0, 8'h00, 32'h0, 1'b1, 1'b1, 1'b1);
    chk("R4 done pulse", {31'b0, xfer_done}, 32'h1);
    chk("R6 reloaded", reg_rdata, 32'h7);
    idle_read("R4 after", 8'h00);
    chk("R4 done one cycle", {31'b0, xfer_done}, 32'h0);

    // R12 shadow write on final strobe
    step("R12 set", 1'b1, 8'h00, 32'h1, 1'b0, 1'b1, 1'b1);
    step("R12 final", 1'b1, 8'h04, 32'h9, 1'b1, 1'b1, 1'b1);
    idle_read("R12 count", 8'h00);
    chk("R12 old shadow copied", reg_rdata, 32'h7);
    idle_read("R12 shadow", 8'h04);
    chk("R12 new shadow kept", reg_rdata, 32'h9);

    // R7 no reload
    step("R7 set", 1'b1, 8'h00, 32'h1, 1'b0, 1'b0, 1'b1);
    step("R7 final", 1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b1);
    chk("R7 count zero", reg_rdata, 32'h0);
    chk("R7 done", {31'b0, xfer_done}, 32'h1);

    // R5 zero means maximum
    step("R5 strobe", 1'b0, 8'h00, 32'h0, 1'b1, 1'b1, 1'b1);
    chk("R5 wraps to max", reg_rdata, 32'h00FFFFFF);
    chk("R5 no done", {31'b0, xfer_done}, 32'h0);

    // R9 write wins over strobe
    step("R9 set", 1'b1, 8'h00, 32'h1, 1'b0, 1'b1, 1'b1);
    step("R9 collide", 1'b1, 8'h00, 32'h0000000A, 1'b1, 1'b1, 1'b1);
    chk("R9 written value", reg_rdata, 32'hA);
    chk("R9 no done", {31'b0, xfer_done}, 32'h0);

    // R10 manual reset keeps shadow
    step("R10 reset", 1'b0, 8'h00, 32'h0, 1'b0, 1'b1, 1'b0);
    chk("R10 count cleared", reg_rdata, 32'h0);
    idle_read("R10 shadow", 8'h04);
    chk("R10 shadow kept", reg_rdata, 32'h9);

    // random mix, checked against the model (R3 R4 R6 R7 R9 R11 R12)
    for (int i = 0; i < 5000; i++) begin
      logic [7:0]  a;
      logic [31:0] wd;
      a  = 8'((($urandom % 4)) * 4);
      wd = ($urandom & 32'hFF000000) | ($urandom % 6);
      step("R3 random", ($urandom % 4) == 0, a, wd, ($urandom % 3) != 0,
           ($urandom % 2) == 0, ($urandom % 150) != 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule